// File: doc/BRIEF.md
# Descriptor-Chain Receive/Transmit DMA Engine

This block moves Ethernet frames between a MAC byte stream and buffer memory under the control of command descriptors that software places in a descriptor memory. Each descriptor carries an opcode, an interrupt condition, a branch condition, a byte count, a buffer address and a branch pointer. Software builds the receive side as a ring of input descriptors that closes with a no-op descriptor branching back to the head. It builds the transmit side as a short chain: one output descriptor followed by a stop descriptor.

For every received frame the engine stores the payload, then appends a two-byte length trailer. It writes a status halfword and a residual count back into the descriptor in one memory write, then moves on to the next descriptor. A completed descriptor whose interrupt condition is "always" raises a level interrupt, which software acknowledges. A descriptor rewritten to the stop opcode parks its channel. After software restores that descriptor, a continue command makes the channel fetch it again.

Top module: `ring_dma`

## Requirements
- R1: A descriptor is four 32-bit words at consecutive word addresses: word 0 holds the opcode in [31:28], the interrupt condition in [21:20], the branch condition in [17:16] and the byte count in [15:0]; word 1 holds the buffer byte address; word 2 holds the branch descriptor address; word 3 receives status in [31:16] and residual in [15:0]. Opcodes are 1 output-last, 3 input-last, 6 no-op and 7 stop; conditions are 0 never and 3 always. Words 0 to 2 are read and word 3 is written once per data descriptor.
- R2: An input-last descriptor stores the received bytes at its buffer address in arrival order, followed by the payload length L as two bytes, high byte first. If L+2 fits the count, the residual is count-(L+2) and the status is 0x8440, so L equals count minus residual minus 2.
- R3: If a frame plus trailer exceeds the count, exactly count bytes are stored and the remaining bytes of that frame are dropped. The residual is 0 and the status is 0x9440 (bit 12 marks truncation). The next frame uses the next descriptor.
- R4: After a descriptor, the next one is the branch address when the branch condition is always, otherwise the current address plus 4. A no-op descriptor with branch always closes the ring.
- R5: Completion of a descriptor with interrupt condition always sets `irq`, which stays high until `irq_clr`. A set in the same cycle as a clear wins. The condition never does not set `irq`.
- R6: Reaching a stop descriptor parks the channel with `rx_ready` low. The stop descriptor raises `irq` only if its interrupt condition is always. The channel's continue input refetches the same descriptor.
- R7: An output-last descriptor reads count bytes from its buffer and presents them on the transmit stream in order. `tx_last` marks the final byte, and data is held while `tx_ready` is low. The writeback status is 0x8440 with residual 0.
- R8: `dma_reset` aborts both channels and clears `irq`. A channel start input loads `start_ptr` and begins fetching there.
- R9: A `halt_req` pulse lets the descriptor in progress finish and parks the channel before it acts on the next one. Continue resumes at that next descriptor.
- R10: After reset `irq`, `rx_ready`, `tx_valid`, `desc_en` and `dmem_we` are low, and `rx_ready` is high only while an input descriptor awaits frame bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start receive channel at start_ptr |
| tx_start | input | 1 | Start transmit channel at start_ptr |
| start_ptr | input | DA_W | Descriptor word address for a start |
| rx_cont | input | 1 | Resume parked receive channel |
| tx_cont | input | 1 | Resume parked transmit channel |
| halt_req | input | 1 | Park both channels at the next descriptor |
| dma_reset | input | 1 | Abort both channels, clear irq |
| irq_clr | input | 1 | Acknowledge interrupt |
| irq | output | 1 | Level interrupt |
| desc_en | output | 1 | Descriptor memory access |
| desc_we | output | 1 | Descriptor memory write |
| desc_addr | output | DA_W | Descriptor word address |
| desc_wdata | output | 32 | Descriptor write data |
| desc_rdata | input | 32 | Descriptor read data, one cycle after read |
| dmem_we | output | 1 | Buffer memory byte write |
| dmem_waddr | output | BA_W | Buffer write byte address |
| dmem_wdata | output | 8 | Buffer write byte |
| dmem_re | output | 1 | Buffer memory byte read |
| dmem_raddr | output | BA_W | Buffer read byte address |
| dmem_rdata | input | 8 | Buffer read byte, one cycle after read |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of frame |
| rx_ready | output | 1 | Receive byte accepted |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Last transmit byte |
| tx_ready | input | 1 | Transmit byte taken |

## Verification
Two functions can land in the same cycle here: a descriptor completion setting the interrupt, and software clearing it. The bench holds `irq_clr` high for the whole of a frame's reception and writeback. It then counts the cycles in which `irq` is seen high while the clear is still asserted. A correct design shows at least one such cycle, because the set must win, and returns to low afterwards. The descriptor status is read back to confirm that the frame completed during that window.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;
  localparam logic [1:0] COND_ALWAYS = 2'd3;
  localparam logic [15:0] ST_DONE    = 16'h8440;
  localparam logic [15:0] ST_TRUNC   = 16'h1000;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RD, SQ_RW, SQ_DEC, SQ_XFER, SQ_WB, SQ_HALT
  } seq_st_e;
endpackage

// File: rtl/dma_desc_arb.sv
module dma_desc_arb #(
  parameter int DA_W = 16
) (
  input  logic            req_a,
  input  logic            we_a,
  input  logic [DA_W-1:0] addr_a,
  input  logic [31:0]     wdata_a,
  input  logic            req_b,
  input  logic            we_b,
  input  logic [DA_W-1:0] addr_b,
  input  logic [31:0]     wdata_b,
  output logic            gnt_a,
  output logic            gnt_b,
  output logic            mem_en,
  output logic            mem_we,
  output logic [DA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata
);
  // fixed priority: channel a (receive) first, it cannot stall the MAC
  assign gnt_a     = req_a;
  assign gnt_b     = req_b && !req_a;
  assign mem_en    = req_a || req_b;
  assign mem_we    = req_a ? we_a    : we_b;
  assign mem_addr  = req_a ? addr_a  : addr_b;
  assign mem_wdata = req_a ? wdata_a : wdata_b;
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq import ring_dma_pkg::*; #(
  parameter int DA_W = 16,
  parameter int BA_W = 16,
  parameter logic [3:0] DATA_OP = OP_IN_LAST
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill,
  input  logic            start,
  input  logic            cont,
  input  logic            halt_req,
  input  logic [DA_W-1:0] start_ptr,
  output logic            desc_req,
  output logic            desc_we,
  output logic [DA_W-1:0] desc_addr,
  output logic [31:0]     desc_wdata,
  input  logic            desc_gnt,
  input  logic [31:0]     desc_rdata,
  output logic            xfer_go,
  output logic [BA_W-1:0] xfer_addr,
  output logic [15:0]     xfer_count,
  input  logic            xfer_done,
  input  logic [15:0]     xfer_status,
  input  logic [15:0]     xfer_resid,
  output logic            done_irq
);
  localparam logic [DA_W-1:0] STRIDE  = DA_W'(4);
  localparam logic [DA_W-1:0] WB_WORD = DA_W'(3);

  seq_st_e         st;
  logic [DA_W-1:0] ptr, bptr, next_ptr;
  logic [BA_W-1:0] daddr;
  logic [1:0]      widx;
  logic [31:0]     w0, wb_q;
  logic            halt_pend;
  logic [3:0]      op;
  logic [1:0]      intc, brc;
  logic            unused_fields;

  assign op   = w0[31:28];
  assign intc = w0[21:20];
  assign brc  = w0[17:16];
  assign unused_fields = ^{w0[27:22], w0[19:18]};
  assign next_ptr = (brc == COND_ALWAYS) ? bptr : ptr + STRIDE;

  assign desc_req   = (st == SQ_RD) || (st == SQ_WB);
  assign desc_we    = (st == SQ_WB);
  assign desc_addr  = ptr + ((st == SQ_WB) ? WB_WORD : DA_W'(widx));
  assign desc_wdata = wb_q;
  assign xfer_go    = (st == SQ_DEC) && !halt_pend && (op == DATA_OP);
  assign xfer_addr  = daddr;
  assign xfer_count = w0[15:0];

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      st        <= SQ_IDLE;
      halt_pend <= 1'b0;
      done_irq  <= 1'b0;
      widx      <= '0;
      ptr       <= '0;
    end else begin
      done_irq <= 1'b0;
      if (halt_req && st != SQ_IDLE && st != SQ_HALT) halt_pend <= 1'b1;
      unique case (st)
        SQ_IDLE: if (start) begin
          ptr  <= start_ptr;
          widx <= '0;
          st   <= SQ_RD;
        end
        SQ_RD: if (desc_gnt) st <= SQ_RW;
        SQ_RW: begin
          unique case (widx)
            2'd0:    w0    <= desc_rdata;
            2'd1:    daddr <= desc_rdata[BA_W-1:0];
            default: bptr  <= desc_rdata[DA_W-1:0];
          endcase
          if (widx == 2'd2) st <= SQ_DEC;
          else begin
            widx <= widx + 2'd1;
            st   <= SQ_RD;
          end
        end
        SQ_DEC: begin
          widx <= '0;
          if (halt_pend) begin
            halt_pend <= 1'b0;
            st        <= SQ_HALT;
          end else if (op == DATA_OP) begin
            st <= SQ_XFER;
          end else if (op == OP_NOP) begin
            done_irq <= (intc == COND_ALWAYS);
            ptr      <= next_ptr;
            st       <= SQ_RD;
          end else begin
            done_irq <= (intc == COND_ALWAYS);
            st       <= SQ_HALT;
          end
        end
        SQ_XFER: if (xfer_done) begin
          wb_q <= {xfer_status, xfer_resid};
          st   <= SQ_WB;
        end
        SQ_WB: if (desc_gnt) begin
          done_irq <= (intc == COND_ALWAYS);
          ptr      <= next_ptr;
          widx     <= '0;
          st       <= SQ_RD;
        end
        SQ_HALT: begin
          widx <= '0;
          if (start) begin
            ptr <= start_ptr;
            st  <= SQ_RD;
          end else if (cont) begin
            st <= SQ_RD;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !kill) |=> (st == SQ_WB)); // R1

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst || kill)
    (st == SQ_HALT && !start && !cont) |=> !desc_req); // R6
endmodule

// File: rtl/dma_rx_mover.sv
module dma_rx_mover import ring_dma_pkg::*; #(
  parameter int BA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill,
  input  logic            go,
  input  logic [BA_W-1:0] base,
  input  logic [15:0]     count,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  output logic            rx_ready,
  output logic            dmem_we,
  output logic [BA_W-1:0] dmem_waddr,
  output logic [7:0]      dmem_wdata,
  output logic            done,
  output logic [15:0]     status,
  output logic [15:0]     resid
);
  typedef enum logic [2:0] {RX_IDLE, RX_DATA, RX_TRL_HI, RX_TRL_LO, RX_FIN} rx_st_e;

  rx_st_e          st;
  logic [BA_W-1:0] base_q;
  logic [15:0]     lim, cnt, flen;
  logic            trunc, fits;

  assign fits       = cnt < lim;
  assign rx_ready   = (st == RX_DATA);
  assign dmem_waddr = base_q + BA_W'(cnt);
  assign done       = (st == RX_FIN);
  assign status     = trunc ? (ST_DONE | ST_TRUNC) : ST_DONE;
  assign resid      = lim - cnt;

  always_comb begin
    dmem_we    = 1'b0;
    dmem_wdata = rx_data;
    unique case (st)
      RX_DATA:   dmem_we = rx_valid && fits;
      RX_TRL_HI: begin dmem_we = fits; dmem_wdata = flen[15:8]; end
      RX_TRL_LO: begin dmem_we = fits; dmem_wdata = flen[7:0];  end
      default:   dmem_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      lim   <= '0;
      flen  <= '0;
      trunc <= 1'b0;
    end else begin
      unique case (st)
        RX_IDLE: if (go) begin
          base_q <= base;
          lim    <= count;
          cnt    <= '0;
          flen   <= '0;
          trunc  <= 1'b0;
          st     <= RX_DATA;
        end
        RX_DATA: if (rx_valid) begin
          if (fits) cnt <= cnt + 16'd1;
          else      trunc <= 1'b1;
          flen <= flen + 16'd1;
          if (rx_last) st <= RX_TRL_HI;
        end
        RX_TRL_HI, RX_TRL_LO: begin
          if (fits) cnt <= cnt + 16'd1;
          else      trunc <= 1'b1;
          st <= (st == RX_TRL_HI) ? RX_TRL_LO : RX_FIN;
        end
        RX_FIN:  st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  AST_RX_GO_IDLE: assert property (@(posedge clk) disable iff (rst || kill)
    go |-> (st == RX_IDLE)); // R2

  AST_RX_TRUNC_FULL: assert property (@(posedge clk) disable iff (rst || kill)
    (done && status[12]) |-> (resid == 16'd0)); // R3
endmodule

// File: rtl/dma_tx_mover.sv
module dma_tx_mover import ring_dma_pkg::*; #(
  parameter int BA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill,
  input  logic            go,
  input  logic [BA_W-1:0] base,
  input  logic [15:0]     count,
  output logic            dmem_re,
  output logic [BA_W-1:0] dmem_raddr,
  input  logic [7:0]      dmem_rdata,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  input  logic            tx_ready,
  output logic            done,
  output logic [15:0]     status,
  output logic [15:0]     resid
);
  typedef enum logic [2:0] {TX_IDLE, TX_RD, TX_WT, TX_OUT, TX_FIN} tx_st_e;

  tx_st_e          st;
  logic [BA_W-1:0] base_q;
  logic [15:0]     lim, cnt;
  logic [7:0]      byte_q;

  assign dmem_re    = (st == TX_RD);
  assign dmem_raddr = base_q + BA_W'(cnt);
  assign tx_valid   = (st == TX_OUT);
  assign tx_data    = byte_q;
  assign tx_last    = tx_valid && (cnt == lim - 16'd1);
  assign done       = (st == TX_FIN);
  assign status     = ST_DONE;
  assign resid      = lim - cnt;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      st     <= TX_IDLE;
      cnt    <= '0;
      lim    <= '0;
      byte_q <= '0;
    end else begin
      unique case (st)
        TX_IDLE: if (go) begin
          base_q <= base;
          lim    <= count;
          cnt    <= '0;
          st     <= (count == 16'd0) ? TX_FIN : TX_RD;
        end
        TX_RD: st <= TX_WT;
        TX_WT: begin
          byte_q <= dmem_rdata;
          st     <= TX_OUT;
        end
        TX_OUT: if (tx_ready) begin
          cnt <= cnt + 16'd1;
          st  <= (cnt + 16'd1 == lim) ? TX_FIN : TX_RD;
        end
        TX_FIN:  st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  AST_TX_GO_IDLE: assert property (@(posedge clk) disable iff (rst || kill)
    go |-> (st == TX_IDLE)); // R7

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst || kill)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7
endmodule

// File: rtl/ring_dma.sv
module ring_dma import ring_dma_pkg::*; #(
  parameter int DA_W = 16,
  parameter int BA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_start,
  input  logic            tx_start,
  input  logic [DA_W-1:0] start_ptr,
  input  logic            rx_cont,
  input  logic            tx_cont,
  input  logic            halt_req,
  input  logic            dma_reset,
  input  logic            irq_clr,
  output logic            irq,
  output logic            desc_en,
  output logic            desc_we,
  output logic [DA_W-1:0] desc_addr,
  output logic [31:0]     desc_wdata,
  input  logic [31:0]     desc_rdata,
  output logic            dmem_we,
  output logic [BA_W-1:0] dmem_waddr,
  output logic [7:0]      dmem_wdata,
  output logic            dmem_re,
  output logic [BA_W-1:0] dmem_raddr,
  input  logic [7:0]      dmem_rdata,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  output logic            rx_ready,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  input  logic            tx_ready
);
  logic            r_req, r_we, r_gnt, r_go, r_done, r_irq;
  logic            t_req, t_we, t_gnt, t_go, t_done, t_irq;
  logic [DA_W-1:0] r_addr, t_addr;
  logic [31:0]     r_wd, t_wd;
  logic [BA_W-1:0] r_base, t_base;
  logic [15:0]     r_cnt, t_cnt, r_st, t_st, r_res, t_res;

  dma_desc_seq #(.DA_W(DA_W), .BA_W(BA_W), .DATA_OP(OP_IN_LAST)) u_rx_seq (
    .clk(clk), .rst(rst), .kill(dma_reset), .start(rx_start), .cont(rx_cont),
    .halt_req(halt_req), .start_ptr(start_ptr),
    .desc_req(r_req), .desc_we(r_we), .desc_addr(r_addr), .desc_wdata(r_wd),
    .desc_gnt(r_gnt), .desc_rdata(desc_rdata),
    .xfer_go(r_go), .xfer_addr(r_base), .xfer_count(r_cnt),
    .xfer_done(r_done), .xfer_status(r_st), .xfer_resid(r_res), .done_irq(r_irq));

  dma_desc_seq #(.DA_W(DA_W), .BA_W(BA_W), .DATA_OP(OP_OUT_LAST)) u_tx_seq (
    .clk(clk), .rst(rst), .kill(dma_reset), .start(tx_start), .cont(tx_cont),
    .halt_req(halt_req), .start_ptr(start_ptr),
    .desc_req(t_req), .desc_we(t_we), .desc_addr(t_addr), .desc_wdata(t_wd),
    .desc_gnt(t_gnt), .desc_rdata(desc_rdata),
    .xfer_go(t_go), .xfer_addr(t_base), .xfer_count(t_cnt),
    .xfer_done(t_done), .xfer_status(t_st), .xfer_resid(t_res), .done_irq(t_irq));

  dma_desc_arb #(.DA_W(DA_W)) u_arb (
    .req_a(r_req), .we_a(r_we), .addr_a(r_addr), .wdata_a(r_wd),
    .req_b(t_req), .we_b(t_we), .addr_b(t_addr), .wdata_b(t_wd),
    .gnt_a(r_gnt), .gnt_b(t_gnt),
    .mem_en(desc_en), .mem_we(desc_we), .mem_addr(desc_addr), .mem_wdata(desc_wdata));

  dma_rx_mover #(.BA_W(BA_W)) u_rx_mv (
    .clk(clk), .rst(rst), .kill(dma_reset), .go(r_go), .base(r_base), .count(r_cnt),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .done(r_done), .status(r_st), .resid(r_res));

  dma_tx_mover #(.BA_W(BA_W)) u_tx_mv (
    .clk(clk), .rst(rst), .kill(dma_reset), .go(t_go), .base(t_base), .count(t_cnt),
    .dmem_re(dmem_re), .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .done(t_done), .status(t_st), .resid(t_res));

  // level interrupt: a new event beats a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst || dma_reset)     irq <= 1'b0;
    else if (r_irq || t_irq)  irq <= 1'b1;
    else if (irq_clr)         irq <= 1'b0;
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst || dma_reset)
    (r_irq || t_irq) |=> irq); // R5

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst || dma_reset)
    (irq && !irq_clr) |=> irq); // R5
endmodule

// File: tb/ring_dma_test.sv
module ring_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int DA_W = 6;
  localparam int BA_W = 10;
  localparam int BUF  = 32;

  logic clk = 1'b0;
  logic rst, rx_start, tx_start, rx_cont, tx_cont, halt_req, dma_reset, irq_clr;
  logic [DA_W-1:0] start_ptr;
  logic irq, desc_en, desc_we, dmem_we, dmem_re;
  logic [DA_W-1:0] desc_addr;
  logic [31:0] desc_wdata, desc_rdata;
  logic [BA_W-1:0] dmem_waddr, dmem_raddr;
  logic [7:0] dmem_wdata, dmem_rdata;
  logic rx_valid, rx_last, rx_ready, tx_valid, tx_last, tx_ready;
  logic [7:0] rx_data, tx_data;

  logic [31:0] dd [0:63];
  logic [7:0]  dm [0:1023];
  logic        bw_en = 1'b0, bm_en = 1'b0;
  logic [5:0]  bw_addr;
  logic [31:0] bw_data;
  logic [9:0]  bm_addr;
  logic [7:0]  bm_data;

  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0;
  int mon_hits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_dma #(.DA_W(DA_W), .BA_W(BA_W)) uut (
    .clk(clk), .rst(rst), .rx_start(rx_start), .tx_start(tx_start), .start_ptr(start_ptr),
    .rx_cont(rx_cont), .tx_cont(tx_cont), .halt_req(halt_req), .dma_reset(dma_reset),
    .irq_clr(irq_clr), .irq(irq), .desc_en(desc_en), .desc_we(desc_we),
    .desc_addr(desc_addr), .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .dmem_re(dmem_re), .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready));

  always @(posedge clk) begin
    if (desc_en && desc_we) dd[desc_addr] <= desc_wdata;
    else if (desc_en)       desc_rdata <= dd[desc_addr];
    if (bw_en) dd[bw_addr] <= bw_data;
    if (dmem_we) dm[dmem_waddr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= dm[dmem_raddr];
    if (bm_en) dm[bm_addr] <= bm_data;
  end

  always @(negedge clk) if (mon_en && irq && irq_clr) mon_hits++;

  function automatic logic [31:0] w0(input logic [3:0] op, input logic [1:0] ic,
                                     input logic [1:0] bc, input int cnt);
    return {op, 4'b0, 2'b0, ic, 2'b0, bc, 16'(cnt)};
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic dwrite(input int a, input logic [31:0] d);
    bw_en = 1'b1; bw_addr = 6'(a); bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic mwrite(input int a, input logic [7:0] d);
    bm_en = 1'b1; bm_addr = 10'(a); bm_data = d;
    @(negedge clk);
    bm_en = 1'b0;
  endtask

  task automatic mk_desc(input int a, input logic [31:0] word0, input int da, input int br);
    dwrite(a, word0); dwrite(a + 1, 32'(da)); dwrite(a + 2, 32'(br)); dwrite(a + 3, 32'h0);
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = pat(seed, i); rx_last = (i == len - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int k;
    k = 0;
    while (!irq && k < 3000) begin @(negedge clk); k++; end
    chk(tag, int'(irq), 1);
  endtask

  task automatic clear_irq(input string tag);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(tag, int'(irq), 0);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  // check one received frame in descriptor d (ring of BUF-byte buffers at 0x100)
  task automatic check_rx(input int d, input int len, input int seed);
    int base, stored, bad, n;
    logic [31:0] w;
    base = 'h100 + BUF * d;
    w = dd[d * 4 + 3];
    stored = len + 2;
    if (stored <= BUF) begin
      chk("R2 status", int'(w[31:16]), 'h8440);
      chk("R2 residual", int'(w[15:0]), BUF - stored);
      chk("R2 length from count-resid-2", BUF - int'(w[15:0]) - 2, len);
      chk("R2 trailer", {dm[base + len], dm[base + len + 1]}, len);
    end else begin
      chk("R3 status truncated", int'(w[31:16]), 'h9440);
      chk("R3 residual zero", int'(w[15:0]), 0);
    end
    n = (len < BUF) ? len : BUF;
    bad = 0;
    for (int i = 0; i < n; i++) if (dm[base + i] != pat(seed, i)) bad++;
    chk((stored <= BUF) ? "R2 payload" : "R3 payload prefix", bad, 0);
  endtask

  task automatic run_all();
    int lens [7] = '{4, 12, 30, 31, 45, 20, 1};
    int got, lastpos, irq_at_last, bad;
    logic [7:0] rec [0:15];

    // reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 irq after reset", int'(irq), 0);
    chk("R10 rx_ready after reset", int'(rx_ready), 0);
    chk("R10 tx_valid after reset", int'(tx_valid), 0);
    chk("R10 desc_en after reset", int'(desc_en), 0);
    chk("R10 dmem_we after reset", int'(dmem_we), 0);

    // ring: 4 input descriptors then a no-op branching to word 0 (R1, R4)
    for (int d = 0; d < 4; d++) mk_desc(d * 4, w0(4'd3, 2'd3, 2'd0, BUF), 'h100 + BUF * d, 0);
    mk_desc(16, w0(4'd6, 2'd0, 2'd3, 0), 0, 0);
    repeat (5) @(negedge clk);
    chk("R10 rx_ready before start", int'(rx_ready), 0);
    start_ptr = 6'd0;
    pulse(rx_start);

    // sweep of lengths across fit, exact fit, trailer split and overflow; wraps the ring
    for (int k = 0; k < 7; k++) begin
      send_frame(lens[k], k + 1);
      wait_irq("R5 irq on completion");
      check_rx(k % 4, lens[k], k + 1);
      if (k == 4) chk("R4 wrap reused buffer 0", int'(dm['h100]), int'(pat(5, 0)));
      clear_irq("R5 irq cleared");
    end

    // set and clear in the same cycle: set must win (R5)
    irq_clr = 1'b1;
    mon_en = 1'b1;
    send_frame(8, 40);
    repeat (40) @(negedge clk);
    mon_en = 1'b0;
    chk("R5 set wins over clear", int'(mon_hits > 0), 1);
    irq_clr = 1'b0;
    @(negedge clk);
    chk("R5 irq low after clear", int'(irq), 0);
    check_rx(3, 8, 40);

    // halt request while a frame is pending (R9)
    pulse(halt_req);
    send_frame(6, 50);
    wait_irq("R9 descriptor in progress completes");
    check_rx(0, 6, 50);
    clear_irq("R9 irq cleared");
    repeat (30) @(negedge clk);
    chk("R9 parked rx_ready low", int'(rx_ready), 0);
    pulse(rx_cont);
    send_frame(9, 51);
    wait_irq("R9 resumed irq");
    check_rx(1, 9, 51);
    clear_irq("R9 irq cleared 2");

    // stop descriptor (R6)
    dwrite(12, w0(4'd7, 2'd0, 2'd0, 0));
    send_frame(5, 60);
    wait_irq("R6 frame before stop");
    check_rx(2, 5, 60);
    clear_irq("R6 irq cleared");
    repeat (30) @(negedge clk);
    chk("R6 stopped rx_ready low", int'(rx_ready), 0);
    chk("R6 stop with never raises no irq", int'(irq), 0);
    dwrite(12, w0(4'd3, 2'd3, 2'd0, BUF));
    dwrite(15, 32'h0);
    pulse(rx_cont);
    send_frame(7, 61);
    wait_irq("R6 continue refetches");
    check_rx(3, 7, 61);
    clear_irq("R6 irq cleared 2");

    // transmit chain (R7)
    for (int i = 0; i < 10; i++) mwrite('h300 + i, 8'('hA0 + i));
    mk_desc(32, w0(4'd1, 2'd0, 2'd0, 10), 'h300, 0);
    mk_desc(36, w0(4'd7, 2'd3, 2'd0, 0), 0, 0);
    start_ptr = 6'd32;
    pulse(tx_start);
    got = 0; lastpos = -1; irq_at_last = -1;
    for (int c = 0; c < 2000 && got < 10; c++) begin
      tx_ready = c[0];
      if (tx_valid && tx_ready) begin
        rec[got] = tx_data;
        if (tx_last) begin lastpos = got; irq_at_last = int'(irq); end
        got++;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) if (rec[i] != 8'('hA0 + i)) bad++;
    chk("R7 transmit bytes", bad, 0);
    chk("R7 transmit byte count", got, 10);
    chk("R7 tx_last position", lastpos, 9);
    chk("R5 never condition leaves irq low", irq_at_last, 0);
    wait_irq("R7 stop descriptor raises irq");
    chk("R7 tx writeback", int'(dd[35]), 'h84400000);
    clear_irq("R7 irq cleared");

    // abort and restart at another descriptor (R8)
    pulse(tx_start);
    @(negedge clk);
    pulse(dma_reset);
    chk("R8 rx_ready after abort", int'(rx_ready), 0);
    chk("R8 irq after abort", int'(irq), 0);
    repeat (10) @(negedge clk);
    chk("R8 idle after abort", int'(desc_en), 0);
    start_ptr = 6'd8;
    pulse(rx_start);
    send_frame(11, 70);
    wait_irq("R8 restart irq");
    check_rx(2, 11, 70);
    clear_irq("R8 irq cleared");
  endtask

  initial begin
    rst = 1'b1; rx_start = 1'b0; tx_start = 1'b0; rx_cont = 1'b0; tx_cont = 1'b0;
    halt_req = 1'b0; dma_reset = 1'b0; irq_clr = 1'b0; start_ptr = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; tx_ready = 1'b0;
    bw_addr = '0; bw_data = '0; bm_addr = '0; bm_data = '0;
    for (int i = 0; i < 64; i++) dd[i] = '0;
    for (int i = 0; i < 1024; i++) dm[i] = '0;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule